// File: doc/BRIEF.md
# Switch-Programmed AES3 Frame Delay Line

This block holds back a stream of AES3 frames by a number of frames picked with two hexadecimal selector codes, one coarse and one fine. Every frame arrives as a single word that carries both subframes along with their preamble and status bits. A one-cycle strobe marks each word, and everything runs in one audio clock domain. The frames are kept in an internal circular buffer. Each word leaves the buffer exactly as it went in, so the delay is counted in frames and the time per step scales with the incoming sample rate.

The two codes combine into a step count, coarse times sixteen plus fine, from 0 to 255. One step is a fixed number of frames, `STEP_FRAMES`. Half an AES block is 96 frames, which is the production value; the default is smaller so that simulation stays short. Code 0 skips the buffer and leaves only a two-register pipeline. The codes are read only on strobe cycles. A new code realigns the read position and mutes the output until the new delay has been filled. The same holds after reset.

Top module: `aes_frame_delay`

## Requirements
- R1: For a nonzero step count S = coarse*16 + fine, each output word, once filled, equals the whole input word (all FRAME_W bits) strobed S*STEP_FRAMES frames earlier. out_valid rises two clock cycles after the strobe of the frame that produces it.
- R2: The largest code, coarse=F and fine=F (255 steps), delays by 255*STEP_FRAMES frames, and the delay stays correct while the pointers wrap past the end of the buffer.
- R3: With both codes 0, each strobed input word shows up on out_frame with out_valid high exactly two clock cycles later, whatever the buffer holds.
- R4: The codes are sampled only in cycles where in_valid is 1. Changing them between strobes and restoring them before the next strobe has no effect on the output.
- R5: When the sampled code differs from the one used on the previous strobe and is nonzero, the output is muted for the next S*STEP_FRAMES strobes (out_valid 0, out_frame 0). After that, output resumes with the first frame written under the new code. A switch to code 0 takes effect at once.
- R6: During and after reset, out_valid and out_frame are 0. The buffer is treated as empty, so a nonzero setting stays muted for its first S*STEP_FRAMES strobes.
- R7: Whenever out_valid is 0, out_frame is all zeros. out_valid is never 1 unless in_valid was 1 two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking one frame word on in_frame |
| in_frame | input | FRAME_W | Complete frame word, both subframes with preambles |
| coarse_sel | input | 4 | Coarse selector code, worth 16 steps per position |
| fine_sel | input | 4 | Fine selector code, worth 1 step per position |
| out_valid | output | 1 | Strobe marking a delayed frame on out_frame |
| out_frame | output | FRAME_W | Delayed frame word, zero when not valid |

## Verification
Four properties are checked on every cycle:
- the two-cycle bypass path;
- the all-zero output word whenever the strobe is low;
- the rule that no output strobe appears without an input strobe two cycles earlier;
- muting right after a code change, and that the read slot never collides with the write slot.

Other behaviour can only be shown by the bench's scenarios, which compare every output word against a frame history kept in the bench:
- that the right frame comes out after hundreds of frames, including across pointer wrap at the largest code;
- that glitches on the selectors between strobes are ignored;
- that output resumes at the right frame after a change or a reset.

// File: rtl/aes_dly_pkg.sv
package aes_dly_pkg;

    typedef logic [3:0] sel_code_t;
    typedef logic [7:0] step_code_t;

    localparam int MAX_STEPS = 255;

endpackage

// File: rtl/aes_dly_steps.sv
module aes_dly_steps
    import aes_dly_pkg::*;
#(
    parameter int STEP_FRAMES = 4,
    parameter int CNT_W       = 10
) (
    input  sel_code_t        coarse,
    input  sel_code_t        fine,
    output step_code_t       code,
    output logic [CNT_W-1:0] frames,
    output logic             zero_set
);

    always_comb begin
        code     = {coarse, fine};
        frames   = CNT_W'(code) * CNT_W'(STEP_FRAMES);
        zero_set = (code == '0);
    end

endmodule

// File: rtl/aes_dly_ram.sv
module aes_dly_ram #(
    parameter int W  = 64,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/aes_dly_ctrl.sv
module aes_dly_ctrl
    import aes_dly_pkg::*;
#(
    parameter int AW    = 10,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  step_code_t       code,
    input  logic [CNT_W-1:0] frames,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic             re,
    output logic [AW-1:0]    raddr,
    output logic             rd_ok,
    output logic             changed
);

    typedef struct packed {
        logic [AW-1:0]    wr_ptr;
        step_code_t       code;
        logic             armed;
        logic [CNT_W-1:0] fill;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        st_d    = st_q;
        changed = strobe && (!st_q.armed || (code != st_q.code));
        cnt     = changed ? '0 : st_q.fill;
        we      = strobe;
        waddr   = st_q.wr_ptr;
        re      = strobe && (frames != '0);
        raddr   = st_q.wr_ptr - AW'(frames);
        rd_ok   = (cnt >= frames);
        if (strobe) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            st_d.code   = code;
            st_d.armed  = 1'b1;
            st_d.fill   = (cnt < frames) ? cnt + 1'b1 : cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the slot being read is never the slot being written
    a_r2_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        re |-> (raddr != waddr));

endmodule

// File: rtl/aes_frame_delay.sv
module aes_frame_delay
    import aes_dly_pkg::*;
#(
    parameter int FRAME_W     = 64,
    parameter int STEP_FRAMES = 4,
    parameter int ADDR_W      = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic [3:0]         coarse_sel,
    input  logic [3:0]         fine_sel,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_frame
);

    localparam int MAX_FRAMES = MAX_STEPS * STEP_FRAMES;
    localparam int CNT_W      = $clog2(MAX_FRAMES + 1);

    if (MAX_FRAMES > (1 << ADDR_W) - 1) begin : g_depth_check
        $error("buffer too shallow for the largest delay");
    end

    typedef struct packed {
        logic               v1;
        logic               byp1;
        logic               ok1;
        logic [FRAME_W-1:0] f1;
        logic               ov;
        logic [FRAME_W-1:0] of;
    } pipe_t;

    pipe_t p_q, p_d;

    step_code_t         code;
    logic [CNT_W-1:0]   frames;
    logic               zero_set;
    logic               we, re, rd_ok, changed;
    logic [ADDR_W-1:0]  waddr, raddr;
    logic [FRAME_W-1:0] rdata;

    aes_dly_steps #(.STEP_FRAMES(STEP_FRAMES), .CNT_W(CNT_W)) u_steps (
        .coarse(coarse_sel), .fine(fine_sel),
        .code(code), .frames(frames), .zero_set(zero_set)
    );

    aes_dly_ctrl #(.AW(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(in_valid), .code(code),
        .frames(frames), .we(we), .waddr(waddr), .re(re), .raddr(raddr),
        .rd_ok(rd_ok), .changed(changed)
    );

    aes_dly_ram #(.W(FRAME_W), .AW(ADDR_W)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(in_frame),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    always_comb begin
        p_d      = p_q;
        p_d.v1   = in_valid;
        p_d.byp1 = zero_set;
        p_d.ok1  = rd_ok;
        p_d.f1   = (in_valid && zero_set) ? in_frame : '0;
        p_d.ov   = p_q.v1 && (p_q.byp1 || p_q.ok1);
        if (!p_d.ov)      p_d.of = '0;
        else if (p_q.byp1) p_d.of = p_q.f1;
        else              p_d.of = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.ov;
    assign out_frame = p_q.of;

    // R3: zero setting passes the word through in two cycles
    a_r3_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(zero_set, 2))
            |-> (out_valid && out_frame == $past(in_frame, 2)));

    // R7: idle output is all zeros
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_frame == '0));

    // R7: no output strobe without an input strobe two cycles before
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R5: a frame arriving with a new nonzero code is muted
    a_r5_mute_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(changed, 2) && !$past(zero_set, 2)) |-> !out_valid);

endmodule

// File: tb/sim_aes_frame_delay.sv
module sim_aes_frame_delay;

    localparam int W    = 64;
    localparam int STEP = 4;
    localparam int AW   = 10;

    // coarse[23:20] fine[19:16] frame count[15:4] cycles per frame[3:0]
    localparam logic [23:0] VEC [8] = '{
        {4'h0, 4'h0, 12'd10,   4'd1},
        {4'h0, 4'h1, 12'd20,   4'd2},
        {4'h0, 4'h3, 12'd30,   4'd1},
        {4'h1, 4'h0, 12'd90,   4'd3},
        {4'h2, 4'h5, 12'd200,  4'd1},
        {4'hF, 4'hF, 12'd1100, 4'd1},
        {4'h0, 4'h0, 12'd5,    4'd2},
        {4'h0, 4'h2, 12'd15,   4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_frame = '0;
    logic [3:0] coarse_sel = '0, fine_sel = '0;
    logic out_valid;
    logic [W-1:0] out_frame;

    always #10 clk = ~clk;

    aes_frame_delay #(.FRAME_W(W), .STEP_FRAMES(STEP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
        .coarse_sel(coarse_sel), .fine_sel(fine_sel),
        .out_valid(out_valid), .out_frame(out_frame)
    );

    int compared = 0;
    int mismatched = 0;

    logic [W-1:0] hist [0:4095];
    int total = 0;
    int fill = 0;
    bit armed = 0;
    logic [7:0] prev_code = '0;

    logic         pv [2];
    logic [W-1:0] pd [2];
    string        pt [2];

    task automatic check(input logic ev, input logic [W-1:0] ed, input string tag);
        compared++;
        if (out_valid !== ev || out_frame !== ed) begin
            mismatched++;
            $display("FAIL %s: valid=%0b frame=%h expected valid=%0b frame=%h",
                     tag, out_valid, out_frame, ev, ed);
        end
    endtask

    function automatic logic [W-1:0] mk_frame(input int n);
        return {32'(n) ^ 32'h5A5A_0000, ~32'(n)};
    endfunction

    task automatic clear_pipe();
        for (int i = 0; i < 2; i++) begin
            pv[i] = 1'b0; pd[i] = '0; pt[i] = "R6";
        end
    endtask

    task automatic tick(input logic v, input logic [3:0] c, input logic [3:0] f,
                        input string force_tag);
        logic [7:0] code;
        int n;
        logic [W-1:0] d;
        @(negedge clk);
        check(pv[1], pd[1], pt[1]);
        pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
        d = mk_frame(total);
        in_valid = v; coarse_sel = c; fine_sel = f; in_frame = d;
        code = {c, f};
        n = int'(code) * STEP;
        if (!v) begin
            pv[0] = 1'b0; pd[0] = '0; pt[0] = "R7";
        end else begin
            string mt;
            mt = armed ? "R5" : "R6";
            if (!armed || code != prev_code) fill = 0;
            armed = 1; prev_code = code;
            if (n == 0) begin
                pv[0] = 1'b1; pd[0] = d; pt[0] = "R3";
            end else if (fill >= n) begin
                pv[0] = 1'b1; pd[0] = hist[total - n];
                pt[0] = (code == 8'hFF) ? "R2" : "R1";
            end else begin
                pv[0] = 1'b0; pd[0] = '0; pt[0] = mt;
            end
            fill++;
            hist[total] = d;
            total++;
        end
        if (force_tag != "") pt[0] = force_tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check(1'b0, '0, "R6");  // outputs cleared while in reset
        @(negedge clk);
        rst_n = 1'b1;
        armed = 0; fill = 0;
        clear_pipe();
    endtask

    initial begin
        clear_pipe();
        repeat (3) @(negedge clk);
        check(1'b0, '0, "R6");  // reset state
        rst_n = 1'b1;

        // vector table walk: R1, R2 (wrap at code FF), R3, R5
        for (int vi = 0; vi < 8; vi++) begin
            for (int k = 0; k < int'(VEC[vi][15:4]); k++) begin
                tick(1'b1, VEC[vi][23:20], VEC[vi][19:16], "");
                for (int g = 1; g < int'(VEC[vi][3:0]); g++)
                    tick(1'b0, VEC[vi][23:20], VEC[vi][19:16], "");
            end
        end

        // R4: selector glitches between strobes leave the delay undisturbed
        for (int k = 0; k < 12; k++) begin
            tick(1'b0, 4'h7, 4'hC, "R4");
            tick(1'b1, 4'h0, 4'h2, "R4");
        end

        // R6: reset mid-stream, buffer treated as empty again
        do_reset();
        for (int k = 0; k < 3 * STEP; k++) tick(1'b1, 4'h0, 4'h1, "");
        // R3: bypass right after reset needs no fill
        do_reset();
        for (int k = 0; k < 4; k++) tick(1'b1, 4'h0, 4'h0, "");
        // R5: leaving bypass mutes, returning to bypass is immediate
        for (int k = 0; k < 2 * STEP + 2; k++) tick(1'b1, 4'h0, 4'h2, "");
        for (int k = 0; k < 3; k++) tick(1'b1, 4'h0, 4'h0, "");
        // R7: idle cycles drain the pipeline
        for (int k = 0; k < 4; k++) tick(1'b0, 4'h0, 4'h0, "");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 100000);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule